// File: doc/BRIEF.md
# Interrupt Moderation and Resend Engine

This block moderates the interrupt requests of a small set of message-signalled interrupt vectors. Each vector collects one-cycle event pulses from its sources. It turns them into a request pulse when enough events have built up, or when a coalescing wait runs out while at least one event is waiting. After a request goes out, the vector stays outstanding until software acknowledges it. If no acknowledge arrives within a programmable number of coalescing periods, the request is sent again.

Software controls each vector through a 32-bit settings word and a write-only clear word, both reached through a simple register write and read port. The coalescing wait is counted in 8 us ticks. A free-running prescaler derives those ticks from the clock-frequency parameter.

Top module: `irq_moderator`

## Requirements
- R1: Vector n has a settings word at byte offset n*8 (address bits 2:0 are zero). All 32 bits read back exactly as written. The fields are: bits 7:0 event limit in units of 8 events; bits 15:8 coalescing period in 8 us ticks; bits 23:16 and 28:24 are stored only and have no effect; bits 31:29 resend count in whole coalescing periods.
- R2: When a vector is idle and its event limit L is non-zero, a request pulse appears on irqMsg one cycle after the waiting event count reaches 8*L. irqPend rises in the same cycle as the pulse.
- R3: An event limit of 0 disables the count trigger, so waiting events alone never raise a request.
- R4: With at least one event waiting and the vector idle, a request is raised once the number of 8 us ticks since the first waiting event reaches the coalescing period.
- R5: A coalescing period of 0 raises a request one cycle after the first event is counted. With the input event in cycle k, irqMsg is high in cycle k+2.
- R6: irqPend stays high until ackIn for that vector is high, and drops in the next cycle. An acknowledge on an idle vector has no effect.
- R7: While a vector is outstanding and unacknowledged, irqMsg pulses again each time the resend count R of whole coalescing periods passes. R = 0 disables resends. Every irqMsg pulse lasts exactly one cycle.
- R8: A write to byte offset n*8+4 with bit 29 set restarts vector n's resend wait. The same write with bit 29 clear has no effect.
- R9: A write whose vector index (address bits above bit 2) is at or above NUM_VEC changes no state. A read at such an index returns 0, and so does a read of any clear word.
- R10: Events that arrive while a vector is outstanding are kept. Once the acknowledge arrives, they trigger the next request under the same rules.
- R11: After reset, all settings words read 0 and irqPend and irqMsg are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte address for write and read |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| evIn | input | NUM_VEC | One-cycle event pulse per vector |
| ackIn | input | NUM_VEC | Software acknowledge per vector |
| irqMsg | output | NUM_VEC | One-cycle request pulse per vector |
| irqPend | output | NUM_VEC | Request outstanding per vector |

## Verification
A wrong event count or wait counter shows at the ports as a request pulse that arrives early, arrives late, or never arrives. The bench catches this in the first cycle where irqMsg differs from a cycle-level model of the requirements. A wrong resend state shows as a missing or extra pulse within one coalescing period times the resend count. A broken address decode shows at once on the next readback.

// File: rtl/irq_mod_pkg.sv
package irq_mod_pkg;
  localparam int TICK_US = 8;
  localparam int RESEND_CLR_BIT = 29;

  typedef struct packed {
    logic attrWe;
    logic resendClr;
  } vecStb_t;
endpackage

// File: rtl/irq_mod_ctrl.sv
module irq_mod_ctrl
  import irq_mod_pkg::*;
#(
  parameter int NUM_VEC = 4,
  parameter int ADDR_W = 8,
  parameter int TICK_CYC = 400,
  parameter int VIDX_W = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [31:0]          regWdata,
  output logic                 tick,
  output vecStb_t              stb [NUM_VEC],
  output logic                 rdHit,
  output logic [VIDX_W-1:0]    rdIdx
);
  localparam int IDX_W = ADDR_W - 3;
  localparam int PRE_W = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;

  logic [PRE_W-1:0] preCnt;
  logic [IDX_W-1:0] idx;
  logic inRange, isCnt;

  // free-running 8 us tick source
  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else if (preCnt == PRE_W'(TICK_CYC - 1)) preCnt <= '0;
    else preCnt <= preCnt + 1'b1;
  end
  assign tick = (preCnt == PRE_W'(TICK_CYC - 1));

  assign idx = regAddr[ADDR_W-1:3];
  assign inRange = (idx < IDX_W'(NUM_VEC));
  assign isCnt = regAddr[2];

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_dec
    logic hit;
    assign hit = regWe && inRange && (idx == IDX_W'(v));
    assign stb[v].attrWe = hit && !isCnt;
    assign stb[v].resendClr = hit && isCnt && regWdata[RESEND_CLR_BIT];
  end

  assign rdHit = inRange && !isCnt;
  assign rdIdx = idx[VIDX_W-1:0];
endmodule

// File: rtl/irq_mod_datapath.sv
module irq_mod_datapath
  import irq_mod_pkg::*;
#(
  parameter int NUM_VEC = 4,
  parameter int VIDX_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  vecStb_t            stb [NUM_VEC],
  input  logic [31:0]        wdata,
  input  logic [NUM_VEC-1:0] evIn,
  input  logic [NUM_VEC-1:0] ackIn,
  input  logic               rdHit,
  input  logic [VIDX_W-1:0]  rdIdx,
  output logic [NUM_VEC-1:0] irqMsg,
  output logic [NUM_VEC-1:0] irqPend,
  output logic [31:0]        rdData
);
  localparam int PEND_W = 12;

  logic [NUM_VEC-1:0][31:0] attrAll;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    logic [31:0] attr;
    logic [PEND_W-1:0] pend;
    logic [7:0] waitCnt, periodCnt, limit, coal, coalEff;
    logic [2:0] resendCnt, resendLim;
    logic busy, msgR, limHit, fire, reFire, periodEnd;

    assign limit = attr[7:0];
    assign coal = attr[15:8];
    assign resendLim = attr[31:29];
    assign coalEff = (coal == 8'd0) ? 8'd1 : coal;

    assign limHit = (limit != 8'd0) && (pend >= {1'b0, limit, 3'b000});
    assign fire = !busy && (pend != '0) && (limHit || (waitCnt >= coal));
    assign reFire = busy && !ackIn[v] && (resendLim != 3'd0) && (resendCnt >= resendLim);
    assign periodEnd = ({1'b0, periodCnt} + 9'd1) >= {1'b0, coalEff};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        attr <= '0;
        pend <= '0;
        waitCnt <= '0;
        periodCnt <= '0;
        resendCnt <= '0;
        busy <= 1'b0;
        msgR <= 1'b0;
      end else begin
        if (stb[v].attrWe) attr <= wdata;
        msgR <= fire || reFire;

        if (fire) pend <= {{(PEND_W-1){1'b0}}, evIn[v]};
        else if (pend != {PEND_W{1'b1}}) pend <= pend + {{(PEND_W-1){1'b0}}, evIn[v]};

        if (fire || busy || pend == '0) waitCnt <= '0;
        else if (tick && waitCnt != 8'hFF) waitCnt <= waitCnt + 8'd1;

        if (fire) busy <= 1'b1;
        else if (ackIn[v]) busy <= 1'b0;

        if (fire || !busy || ackIn[v] || stb[v].resendClr || reFire) begin
          periodCnt <= '0;
          resendCnt <= '0;
        end else if (tick) begin
          if (periodEnd) begin
            periodCnt <= '0;
            if (resendCnt != 3'd7) resendCnt <= resendCnt + 3'd1;
          end else begin
            periodCnt <= periodCnt + 8'd1;
          end
        end
      end
    end

    assign irqMsg[v] = msgR;
    assign irqPend[v] = busy;
    assign attrAll[v] = attr;
  end

  assign rdData = rdHit ? attrAll[rdIdx] : 32'd0;
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
  import irq_mod_pkg::*;
#(
  parameter int NUM_VEC = 4,
  parameter int ADDR_W = 8,
  parameter int CLK_HZ = 50_000_000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  input  logic [NUM_VEC-1:0] evIn,
  input  logic [NUM_VEC-1:0] ackIn,
  output logic [NUM_VEC-1:0] irqMsg,
  output logic [NUM_VEC-1:0] irqPend
);
  localparam int TICK_CYC = (CLK_HZ / 1_000_000) * TICK_US;
  localparam int VIDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  vecStb_t stb [NUM_VEC];
  logic tick, rdHit;
  logic [VIDX_W-1:0] rdIdx;

  irq_mod_ctrl #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .TICK_CYC(TICK_CYC), .VIDX_W(VIDX_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .tick(tick), .stb(stb), .rdHit(rdHit), .rdIdx(rdIdx)
  );

  irq_mod_datapath #(.NUM_VEC(NUM_VEC), .VIDX_W(VIDX_W)) i_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .stb(stb), .wdata(regWdata),
    .evIn(evIn), .ackIn(ackIn), .rdHit(rdHit), .rdIdx(rdIdx),
    .irqMsg(irqMsg), .irqPend(irqPend), .rdData(regRdata)
  );
endmodule

// File: rtl/irq_moderator_chk.sv
module irq_moderator_chk #(
  parameter int NUM_VEC = 4,
  parameter int ADDR_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [31:0]        regRdata,
  input logic [NUM_VEC-1:0] ackIn,
  input logic [NUM_VEC-1:0] irqMsg,
  input logic [NUM_VEC-1:0] irqPend
);
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_chk
    p_msg_in_pend_r6: assert property (@(posedge clk) disable iff (!rstN)
      irqMsg[v] |-> irqPend[v]);
    p_rise_with_msg_r2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irqPend[v]) |-> irqMsg[v]);
    p_ack_drops_r6: assert property (@(posedge clk) disable iff (!rstN)
      (irqPend[v] && ackIn[v]) |=> !irqPend[v]);
    p_pend_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
      (irqPend[v] && !ackIn[v]) |=> irqPend[v]);
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
      irqMsg[v] |=> !irqMsg[v]);
  end

  p_oob_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr[ADDR_W-1:3] >= (ADDR_W-3)'(NUM_VEC)) |-> (regRdata == 32'd0));
  p_clr_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    regAddr[2] |-> (regRdata == 32'd0));
endmodule

bind irq_moderator irq_moderator_chk #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRdata(regRdata),
  .ackIn(ackIn), .irqMsg(irqMsg), .irqPend(irqPend)
);

// File: tb/test_irq_moderator.sv
module test_irq_moderator;
  localparam int NV = 4;
  localparam int AW = 8;
  localparam int TICKC = 8; // CLK_HZ of 1 MHz gives 8 cycles per tick

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [NV-1:0] evIn = '0;
  logic [NV-1:0] ackIn = '0;
  logic [NV-1:0] irqMsg, irqPend;

  int nChk = 0, nFail = 0;
  string curReq = "R11";
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  irq_moderator #(.NUM_VEC(NV), .ADDR_W(AW), .CLK_HZ(1_000_000)) i_irq_moderator (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .evIn(evIn), .ackIn(ackIn), .irqMsg(irqMsg), .irqPend(irqPend)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model of the requirements, cycle level
  logic [31:0] mAttr [NV];
  int mPend [NV], mWait [NV], mPt [NV], mRs [NV], mPre;
  bit mBusy [NV], mMsg [NV];
  int msgCnt [NV];

  function automatic bit fireNow(int v);
    int lim = int'(mAttr[v][7:0]);
    int coal = int'(mAttr[v][15:8]);
    return !mBusy[v] && mPend[v] != 0 && ((lim != 0 && mPend[v] >= lim * 8) || mWait[v] >= coal);
  endfunction

  function automatic bit resendNow(int v);
    int rl = int'(mAttr[v][31:29]);
    return mBusy[v] && !ackIn[v] && rl != 0 && mRs[v] >= rl;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPre <= 0;
      for (int v = 0; v < NV; v++) begin
        mAttr[v] <= '0; mPend[v] <= 0; mWait[v] <= 0; mPt[v] <= 0;
        mRs[v] <= 0; mBusy[v] <= 0; mMsg[v] <= 0;
      end
    end else begin
      automatic bit tk = (mPre == TICKC - 1);
      automatic int idx = int'(regAddr[AW-1:3]);
      mPre <= tk ? 0 : mPre + 1;
      for (int v = 0; v < NV; v++) begin
        automatic bit f = fireNow(v);
        automatic bit rf = resendNow(v);
        automatic int ce = (mAttr[v][15:8] == 0) ? 1 : int'(mAttr[v][15:8]);
        automatic bit clr = regWe && idx == v && regAddr[2] && regWdata[29];
        mMsg[v] <= f || rf;
        if (f) mPend[v] <= int'(evIn[v]);
        else if (mPend[v] < 4095) mPend[v] <= mPend[v] + int'(evIn[v]);
        if (f || mBusy[v] || mPend[v] == 0) mWait[v] <= 0;
        else if (tk && mWait[v] < 255) mWait[v] <= mWait[v] + 1;
        if (f) mBusy[v] <= 1'b1;
        else if (ackIn[v]) mBusy[v] <= 1'b0;
        if (f || !mBusy[v] || ackIn[v] || clr || rf) begin
          mPt[v] <= 0; mRs[v] <= 0;
        end else if (tk) begin
          if (mPt[v] + 1 >= ce) begin
            mPt[v] <= 0;
            if (mRs[v] < 7) mRs[v] <= mRs[v] + 1;
          end else mPt[v] <= mPt[v] + 1;
        end
        if (regWe && idx == v && !regAddr[2]) mAttr[v] <= regWdata;
      end
    end
  end

  // continuous comparison against the model, plus pulse counting
  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int v = 0; v < NV; v++) begin
        check(irqMsg[v] == mMsg[v], {curReq, " irqMsg"}, 32'(irqMsg[v]), 32'(mMsg[v]));
        check(irqPend[v] == mBusy[v], {curReq, " irqPend"}, 32'(irqPend[v]), 32'(mBusy[v]));
        if (irqMsg[v]) msgCnt[v]++;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    cyc(1);
    regWe = 1'b0;
  endtask

  task automatic rdChk(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    regAddr = a;
    #1;
    check(regRdata == exp, req, regRdata, exp);
  endtask

  task automatic events(input int v, input int n);
    repeat (n) begin
      evIn[v] = 1'b1;
      cyc(1);
    end
    evIn[v] = 1'b0;
  endtask

  task automatic ack(input int v);
    ackIn[v] = 1'b1;
    cyc(1);
    ackIn[v] = 1'b0;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    int base;
    logic [31:0] rv;
    for (int v = 0; v < NV; v++) msgCnt[v] = 0;
    void'($urandom(32'd4711));
    cyc(4);
    rstN = 1'b1;
    cyc(1);
    @(negedge clk);
    // R11 reset state
    check(irqPend == '0, "R11", 32'(irqPend), 0);
    check(irqMsg == '0, "R11", 32'(irqMsg), 0);
    for (int v = 0; v < NV; v++) rdChk(AW'(v * 8), 32'd0, "R11");
    cyc(1);

    // R1 readback of all bits, including stored-only fields
    curReq = "R1";
    rv = $urandom();
    wr(8'h10, rv);
    rdChk(8'h10, rv, "R1");
    rdChk(8'h14, 32'd0, "R9 clear word reads 0");

    // R9 out-of-range writes ignored
    curReq = "R9";
    wr(8'h00, 32'h0000FF01);
    wr(8'h20, 32'hFFFFFFFF);
    wr(8'hF8, 32'hFFFFFFFF);
    rdChk(8'h20, 32'd0, "R9");
    rdChk(8'h00, 32'h0000FF01, "R9");
    rdChk(8'h10, rv, "R9");
    check(irqPend == '0, "R9", 32'(irqPend), 0);

    // R2 count trigger: limit 1 -> 8 events
    curReq = "R2";
    events(0, 7);
    cyc(5);
    check(msgCnt[0] == 0, "R2 below limit", msgCnt[0], 0);
    events(0, 1);
    cyc(3);
    check(msgCnt[0] == 1, "R2", msgCnt[0], 1);
    check(irqPend[0] == 1'b1, "R2", 32'(irqPend[0]), 1);

    // R6 acknowledge, then ack on idle vector
    curReq = "R6";
    cyc(20);
    check(irqPend[0] == 1'b1, "R6 holds", 32'(irqPend[0]), 1);
    ack(0);
    check(irqPend[0] == 1'b0, "R6 ack", 32'(irqPend[0]), 0);
    ack(0);
    cyc(3);
    check(irqPend[0] == 1'b0 && msgCnt[0] == 1, "R6 idle ack", msgCnt[0], 1);

    // R3 limit 0 and R4 coalescing period 3 ticks
    curReq = "R3";
    wr(8'h08, 32'h00000300);
    events(1, 15);
    cyc(1);
    check(msgCnt[1] == 0, "R3", msgCnt[1], 0);
    curReq = "R4";
    cyc(40);
    check(msgCnt[1] == 1, "R4", msgCnt[1], 1);
    ack(1);

    // R5 period 0
    curReq = "R5";
    wr(8'h10, 32'h00000000);
    evIn[2] = 1'b1;
    cyc(1);
    evIn[2] = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(irqMsg[2] == 1'b1, "R5", 32'(irqMsg[2]), 1);
    cyc(2);
    ack(2);

    // R7 resend every 2 periods of 2 ticks
    curReq = "R7";
    wr(8'h18, 32'h40000201);
    base = msgCnt[3];
    events(3, 8);
    cyc(80);
    check(msgCnt[3] - base >= 3 && msgCnt[3] - base <= 4, "R7 resend", msgCnt[3] - base, 3);
    ack(3);
    wr(8'h18, 32'h00000201);
    base = msgCnt[3];
    events(3, 8);
    cyc(150);
    check(msgCnt[3] - base == 1, "R7 disabled", msgCnt[3] - base, 1);
    ack(3);

    // R8 clear word restarts the resend wait
    curReq = "R8";
    wr(8'h18, 32'h20000401);
    base = msgCnt[3];
    events(3, 8);
    repeat (10) begin
      cyc(15);
      wr(8'h1C, 32'h20000000);
    end
    check(msgCnt[3] - base == 1, "R8 clear", msgCnt[3] - base, 1);
    repeat (5) begin
      cyc(15);
      wr(8'h1C, 32'hDFFFFFFF);
    end
    check(msgCnt[3] - base >= 2, "R8 bit29 clear no effect", msgCnt[3] - base, 2);
    ack(3);

    // R10 events while outstanding trigger after ack
    curReq = "R10";
    base = msgCnt[0];
    events(0, 8);
    cyc(2);
    events(0, 8);
    cyc(3);
    check(msgCnt[0] - base == 1, "R10 held", msgCnt[0] - base, 1);
    ack(0);
    cyc(3);
    check(msgCnt[0] - base == 2, "R10 after ack", msgCnt[0] - base, 2);
    ack(0);

    // constrained random phase, checked against the model each cycle
    curReq = "R2 R4 R7 R10 random";
    for (int i = 0; i < 3000; i++) begin
      for (int v = 0; v < NV; v++) begin
        evIn[v] = ($urandom_range(2) == 0);
        ackIn[v] = ($urandom_range(9) == 0);
      end
      if ($urandom_range(40) == 0) begin
        automatic logic [31:0] w = $urandom();
        w[15:8] = 8'($urandom_range(3));
        w[7:0] = 8'($urandom_range(2));
        regWe = 1'b1;
        regAddr = {3'($urandom_range(4)), ($urandom_range(3) == 0), 2'b00};
        regWdata = w;
      end else regWe = 1'b0;
      cyc(1);
    end
    regWe = 1'b0; evIn = '0; ackIn = '0;
    cyc(5);
    finishRun();
  end
endmodule